// File: doc/BRIEF.md
# Retransmit Packet Descriptor Manager

This block keeps the bookkeeping for a ring of packet slots held on chip, so that data sent over a lossy link can be sent again until the far end acknowledges it. Each slot has a small descriptor: a generation number (the "set" the slot's packet belongs to) and three flags. The flags say whether the slot holds a packet ready to go, whether that packet has gone out at least once, and whether its receipt has been acknowledged. A producer fills slots in ring order at the head. A transmit engine takes the packets that the block offers. Acknowledgements mark slots done, and the tail then moves past them so the producer can reuse them for the next generation.

The packets to send are not kept in a queue. A scanner walks the ring one slot per cycle and offers any slot that is ready and not yet acknowledged. Because of this, an unacknowledged packet comes back on a later pass of the scanner with no timer. Each hand-off raises one pulse that tells a first transmission apart from a repeat, which lets a rate-control loop outside the block count the repeats. Payload storage and link framing belong to the neighbouring blocks.

Top module: `retx_desc_mgr`

## Requirements
- R1: After reset the ring is empty. `fill_ready_o` is 1, `fill_slot_o` is 0, `fill_set_o` is 0, `tx_valid_o` is 0, and both grant pulses are 0.
- R2: When `fill_req_i` is high and `fill_ready_o` is 1, the slot at `fill_slot_o` is loaded with generation `fill_set_o`. It is marked ready, not sent and not acknowledged. `fill_slot_o` then moves to the next index, and after NSLOTS-1 it goes back to 0.
- R3: When NSLOTS slots lie between the tail and the head, `fill_ready_o` is 0. A fill request in that state changes nothing.
- R4: Slots are offered only while the block runs. `start_i` makes it run from the next cycle. `stop_i` removes any offer in the same cycle and halts the block. If both are high in the same cycle, stop wins.
- R5: The scanner visits slot indices in increasing cyclic order and offers only slots that are ready and not acknowledged. An offer stays stable on `tx_slot_o` and `tx_set_o` until `tx_ready_i` accepts it.
- R6: The cycle after an accepted offer, exactly one pulse is raised. It is `first_send_o` if the slot had not been sent before, and `retx_o` otherwise. The slot is then marked sent.
- R7: A slot that has been sent but not acknowledged is offered again on a later pass of the scanner.
- R8: An acknowledge on `ack_slot_i` takes effect only if that slot is ready, has been sent, is not yet acknowledged, and holds generation `ack_set_i`. Any other acknowledge is ignored.
- R9: An acknowledged slot is never offered again until it is refilled.
- R10: The tail moves forward by at most one slot per cycle, and only while the slot at the tail is acknowledged. An acknowledged slot that lies behind an unacknowledged one frees no space.
- R11: The generation given to fills goes up by one, modulo 2^SETW, each time the head wraps from slot NSLOTS-1 to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin offering slots |
| stop_i | input | 1 | Halt offering at once |
| fill_req_i | input | 1 | Producer writes a packet into the head slot |
| fill_ready_o | output | 1 | A free slot is available at the head |
| fill_slot_o | output | IDXW | Slot index that the next fill will take |
| fill_set_o | output | SETW | Generation that the next fill will be given |
| tx_valid_o | output | 1 | A slot is offered for transmission |
| tx_ready_i | input | 1 | Transmit engine accepts the offer |
| tx_slot_o | output | IDXW | Offered slot index |
| tx_set_o | output | SETW | Generation of the offered slot |
| first_send_o | output | 1 | Pulse: the accepted slot is going out for the first time |
| retx_o | output | 1 | Pulse: the accepted slot is going out again |
| ack_i | input | 1 | Acknowledge strobe |
| ack_slot_i | input | IDXW | Slot being acknowledged |
| ack_set_i | input | SETW | Generation being acknowledged |

## Verification
On every cycle, the assertions check the following. The head moves one step per accepted fill. The generation steps when the head wraps. A full ring holds still. Stop removes the offer. An offer holds until accepted. Every accepted offer gives exactly one pulse the next cycle, and every pulse follows an accepted offer.

Some behaviours depend on the descriptor history of particular slots, and only the bench scenarios can show them. These are: stale-generation and not-yet-sent acknowledges being ignored, the tail being blocked behind an unacknowledged slot, acknowledged slots dropping out of a full scan pass, repeats appearing on the second pass, and a fill sweep over several wraps with the expected slot and generation worked out for each fill.

// File: rtl/retx_desc_pkg.sv
`timescale 1ns/1ps
package retx_desc_pkg;

    // Per-slot status flags
    typedef struct packed {
        logic ready;   // holds a packet to be sent
        logic sent;    // has gone out at least once
        logic done;    // receipt acknowledged
    } slot_flags_t;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_mode_e;

endpackage

// File: rtl/retx_desc_table.sv
`timescale 1ns/1ps
module retx_desc_table
    import retx_desc_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int SETW   = 4,
    localparam int IDXW  = $clog2(NSLOTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fill_we,
    input  logic [IDXW-1:0]                   fill_idx,
    input  logic [SETW-1:0]                   fill_set,
    input  logic                              grant_we,
    input  logic [IDXW-1:0]                   grant_idx,
    input  logic                              ack_i,
    input  logic [IDXW-1:0]                   ack_idx,
    input  logic [SETW-1:0]                   ack_set,
    output slot_flags_t [NSLOTS-1:0]          flags_o,
    output logic [NSLOTS-1:0][SETW-1:0]       sets_o
);

    typedef struct packed {
        slot_flags_t [NSLOTS-1:0]    flags;
        logic [NSLOTS-1:0][SETW-1:0] sets;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic ack_hit;

    always_comb begin
        tbl_d = tbl_q;
        // acknowledge accepted only for a sent, open slot of the same generation
        ack_hit = ack_i
                  && tbl_q.flags[ack_idx].ready
                  && tbl_q.flags[ack_idx].sent
                  && !tbl_q.flags[ack_idx].done
                  && (tbl_q.sets[ack_idx] == ack_set);
        if (grant_we) begin
            tbl_d.flags[grant_idx].sent = 1'b1;
        end
        if (ack_hit) begin
            tbl_d.flags[ack_idx].done = 1'b1;
        end
        if (fill_we) begin
            tbl_d.flags[fill_idx] = '{ready: 1'b1, sent: 1'b0, done: 1'b0};
            tbl_d.sets[fill_idx]  = fill_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign flags_o = tbl_q.flags;
    assign sets_o  = tbl_q.sets;

endmodule

// File: rtl/retx_window.sv
`timescale 1ns/1ps
module retx_window #(
    parameter int NSLOTS = 32,
    parameter int SETW   = 4,
    localparam int IDXW  = $clog2(NSLOTS),
    localparam int CNTW  = $clog2(NSLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_req_i,
    input  logic            tail_done_i,
    output logic            fill_take_o,
    output logic            fill_ready_o,
    output logic [IDXW-1:0] head_o,
    output logic [IDXW-1:0] tail_o,
    output logic [SETW-1:0] head_set_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSLOTS - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(NSLOTS);

    typedef struct packed {
        logic [IDXW-1:0] head;
        logic [IDXW-1:0] tail;
        logic [CNTW-1:0] count;
        logic [SETW-1:0] set;
    } win_t;

    win_t win_d, win_q;
    logic take, retire;

    always_comb begin
        win_d  = win_q;
        take   = fill_req_i && (win_q.count != FULL_CNT);
        retire = (win_q.count != '0) && tail_done_i;
        if (take) begin
            if (win_q.head == LAST_IDX) begin
                win_d.head = '0;
                win_d.set  = win_q.set + 1'b1;
            end else begin
                win_d.head = win_q.head + 1'b1;
            end
        end
        if (retire) begin
            win_d.tail = (win_q.tail == LAST_IDX) ? '0 : win_q.tail + 1'b1;
        end
        case ({take, retire})
            2'b10:   win_d.count = win_q.count + 1'b1;
            2'b01:   win_d.count = win_q.count - 1'b1;
            default: win_d.count = win_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign fill_take_o  = take;
    assign fill_ready_o = (win_q.count != FULL_CNT);
    assign head_o       = win_q.head;
    assign tail_o       = win_q.tail;
    assign head_set_o   = win_q.set;

endmodule

// File: rtl/retx_scanner.sv
`timescale 1ns/1ps
module retx_scanner
    import retx_desc_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int SETW   = 4,
    localparam int IDXW  = $clog2(NSLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        stop_i,
    input  logic                        tx_ready_i,
    input  slot_flags_t [NSLOTS-1:0]    flags_i,
    input  logic [NSLOTS-1:0][SETW-1:0] sets_i,
    output logic                        tx_valid_o,
    output logic [IDXW-1:0]             tx_slot_o,
    output logic [SETW-1:0]             tx_set_o,
    output logic                        grant_o,
    output logic                        first_send_o,
    output logic                        retx_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSLOTS - 1);

    typedef struct packed {
        scan_mode_e      mode;
        logic [IDXW-1:0] pos;
        logic            first;
        logic            again;
    } scan_t;

    scan_t scn_d, scn_q;
    logic  cand, live, grant;

    always_comb begin
        scn_d = scn_q;
        cand  = flags_i[scn_q.pos].ready && !flags_i[scn_q.pos].done;
        live  = (scn_q.mode == SCAN_RUN) && !stop_i;
        grant = live && cand && tx_ready_i;

        if (stop_i) begin
            scn_d.mode = SCAN_IDLE;
        end else if (start_i) begin
            scn_d.mode = SCAN_RUN;
        end

        // step past empty/finished slots, hold on a pending offer
        if (live && (!cand || grant)) begin
            scn_d.pos = (scn_q.pos == LAST_IDX) ? '0 : scn_q.pos + 1'b1;
        end

        scn_d.first = grant && !flags_i[scn_q.pos].sent;
        scn_d.again = grant &&  flags_i[scn_q.pos].sent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scn_q <= '{mode: SCAN_IDLE, pos: '0, first: 1'b0, again: 1'b0};
        end else begin
            scn_q <= scn_d;
        end
    end

    assign tx_valid_o   = live && cand;
    assign tx_slot_o    = scn_q.pos;
    assign tx_set_o     = sets_i[scn_q.pos];
    assign grant_o      = grant;
    assign first_send_o = scn_q.first;
    assign retx_o       = scn_q.again;

endmodule

// File: rtl/retx_desc_mgr.sv
`timescale 1ns/1ps
module retx_desc_mgr
    import retx_desc_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int SETW   = 4,
    localparam int IDXW  = $clog2(NSLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            fill_req_i,
    output logic            fill_ready_o,
    output logic [IDXW-1:0] fill_slot_o,
    output logic [SETW-1:0] fill_set_o,
    output logic            tx_valid_o,
    input  logic            tx_ready_i,
    output logic [IDXW-1:0] tx_slot_o,
    output logic [SETW-1:0] tx_set_o,
    output logic            first_send_o,
    output logic            retx_o,
    input  logic            ack_i,
    input  logic [IDXW-1:0] ack_slot_i,
    input  logic [SETW-1:0] ack_set_i
);

    slot_flags_t [NSLOTS-1:0]    flags;
    logic [NSLOTS-1:0][SETW-1:0] sets;
    logic                        fill_take;
    logic                        grant;
    logic [IDXW-1:0]             head, tail;
    logic [SETW-1:0]             head_set;

    retx_window #(.NSLOTS(NSLOTS), .SETW(SETW)) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_req_i   (fill_req_i),
        .tail_done_i  (flags[tail].done),
        .fill_take_o  (fill_take),
        .fill_ready_o (fill_ready_o),
        .head_o       (head),
        .tail_o       (tail),
        .head_set_o   (head_set)
    );

    retx_desc_table #(.NSLOTS(NSLOTS), .SETW(SETW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_take),
        .fill_idx  (head),
        .fill_set  (head_set),
        .grant_we  (grant),
        .grant_idx (tx_slot_o),
        .ack_i     (ack_i),
        .ack_idx   (ack_slot_i),
        .ack_set   (ack_set_i),
        .flags_o   (flags),
        .sets_o    (sets)
    );

    retx_scanner #(.NSLOTS(NSLOTS), .SETW(SETW)) u_scanner (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .tx_ready_i   (tx_ready_i),
        .flags_i      (flags),
        .sets_i       (sets),
        .tx_valid_o   (tx_valid_o),
        .tx_slot_o    (tx_slot_o),
        .tx_set_o     (tx_set_o),
        .grant_o      (grant),
        .first_send_o (first_send_o),
        .retx_o       (retx_o)
    );

    assign fill_slot_o = head;
    assign fill_set_o  = head_set;

endmodule

// File: rtl/retx_desc_mgr_chk.sv
`timescale 1ns/1ps
module retx_desc_mgr_chk #(
    parameter int NSLOTS = 32,
    parameter int SETW   = 4,
    localparam int IDXW  = $clog2(NSLOTS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_i,
    input logic            fill_req_i,
    input logic            fill_ready_o,
    input logic [IDXW-1:0] fill_slot_o,
    input logic [SETW-1:0] fill_set_o,
    input logic            tx_valid_o,
    input logic            tx_ready_i,
    input logic [IDXW-1:0] tx_slot_o,
    input logic            first_send_o,
    input logic            retx_o,
    input logic            ack_i,
    input logic [IDXW-1:0] ack_slot_i
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSLOTS - 1);

    // R2: head steps by one, wrapping at the last slot
    a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_i && fill_ready_o) |=>
            (fill_slot_o == (($past(fill_slot_o) == LAST_IDX) ? '0 : $past(fill_slot_o) + 1'b1)));

    // R3: full ring ignores fill requests
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_i && !fill_ready_o) |=> ($stable(fill_slot_o) && $stable(fill_set_o)));

    // R11: generation steps modulo on head wrap
    a_r11_set_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_i && fill_ready_o && fill_slot_o == LAST_IDX) |=>
            (fill_set_o == SETW'($past(fill_set_o) + 1'b1)));

    // R4: stop halts offering
    a_r4_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !tx_valid_o);

    // R5: pending offer is held until accepted
    a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !stop_i && !(ack_i && ack_slot_i == tx_slot_o)) |=>
            (stop_i || (tx_valid_o && $stable(tx_slot_o))));

    // R6: every accepted offer yields a pulse next cycle
    a_r6_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i) |=> (first_send_o || retx_o));

    // R6: pulses only follow an accepted offer
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (first_send_o || retx_o) |-> $past(tx_valid_o && tx_ready_i));

    // R6: never both kinds at once
    a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({first_send_o, retx_o}) <= 1);

endmodule

bind retx_desc_mgr retx_desc_mgr_chk #(.NSLOTS(NSLOTS), .SETW(SETW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_i       (stop_i),
    .fill_req_i   (fill_req_i),
    .fill_ready_o (fill_ready_o),
    .fill_slot_o  (fill_slot_o),
    .fill_set_o   (fill_set_o),
    .tx_valid_o   (tx_valid_o),
    .tx_ready_i   (tx_ready_i),
    .tx_slot_o    (tx_slot_o),
    .first_send_o (first_send_o),
    .retx_o       (retx_o),
    .ack_i        (ack_i),
    .ack_slot_i   (ack_slot_i)
);

// File: tb/tb_retx_desc_mgr.sv
`timescale 1ns/1ps
module tb_retx_desc_mgr;

    localparam int N    = 8;
    localparam int SW   = 2;
    localparam int IW   = $clog2(N);
    localparam int NSET = 1 << SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, fill_req_i = 0, tx_ready_i = 0, ack_i = 0;
    logic [IW-1:0] ack_slot_i = '0;
    logic [SW-1:0] ack_set_i = '0;
    logic fill_ready_o, tx_valid_o, first_send_o, retx_o;
    logic [IW-1:0] fill_slot_o, tx_slot_o;
    logic [SW-1:0] fill_set_o, tx_set_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    retx_desc_mgr #(.NSLOTS(N), .SETW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .fill_req_i(fill_req_i), .fill_ready_o(fill_ready_o),
        .fill_slot_o(fill_slot_o), .fill_set_o(fill_set_o),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .tx_slot_o(tx_slot_o), .tx_set_o(tx_set_o),
        .first_send_o(first_send_o), .retx_o(retx_o),
        .ack_i(ack_i), .ack_slot_i(ack_slot_i), .ack_set_i(ack_set_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 0; start_i = 0; stop_i = 0; fill_req_i = 0; tx_ready_i = 0; ack_i = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic do_fill(input int exp_slot, input int exp_set, input string req);
        check(fill_ready_o == 1'b1, req, "fill ready", int'(fill_ready_o), 1);
        check(int'(fill_slot_o) == exp_slot, req, "fill slot", int'(fill_slot_o), exp_slot);
        check(int'(fill_set_o) == exp_set, req, "fill set", int'(fill_set_o), exp_set);
        fill_req_i = 1; tick(1); fill_req_i = 0;
    endtask

    task automatic do_ack(input int slot, input int set);
        ack_i = 1; ack_slot_i = IW'(slot); ack_set_i = SW'(set);
        tick(1);
        ack_i = 0;
    endtask

    task automatic pulse_cmd(input bit s, input bit p);
        start_i = s; stop_i = p; tick(1); start_i = 0; stop_i = 0;
    endtask

    // wait for an offer, accept it, report slot, set and pulse kind
    task automatic grab(output int slot, output int set, output int again);
        bit seen = 0;
        for (int i = 0; i < 4 * N; i++) begin
            if (tx_valid_o) begin seen = 1; break; end
            tick(1);
        end
        check(seen, "R5", "offer appears", int'(seen), 1);
        slot = int'(tx_slot_o);
        set  = int'(tx_set_o);
        tx_ready_i = 1; tick(1); tx_ready_i = 0;
        check((first_send_o ^ retx_o) == 1'b1, "R6", "one pulse",
              int'({first_send_o, retx_o}), 1);
        again = int'(retx_o);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual 20000 expected fewer cycles");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int s, st, ag;
        int seen_mask;
        do_reset();

        // R1: reset state
        check(fill_ready_o == 1, "R1", "ready", int'(fill_ready_o), 1);
        check(fill_slot_o == 0, "R1", "slot", int'(fill_slot_o), 0);
        check(fill_set_o == 0, "R1", "set", int'(fill_set_o), 0);
        check(tx_valid_o == 0, "R1", "no offer", int'(tx_valid_o), 0);
        check({first_send_o, retx_o} == 2'b00, "R1", "pulses", int'({first_send_o, retx_o}), 0);

        // R2: three fills before start
        for (int k = 0; k < 3; k++) do_fill(k, 0, "R2");
        tick(3);
        check(tx_valid_o == 0, "R4", "no offer before start", int'(tx_valid_o), 0);

        pulse_cmd(1, 0);
        // R5 order and R6 first send
        for (int k = 0; k < 3; k++) begin
            grab(s, st, ag);
            check(s == k, "R5", "first pass slot", s, k);
            check(st == 0, "R5", "first pass set", st, 0);
            check(ag == 0, "R6", "first send kind", ag, 0);
        end
        // R7: slot 0 offered again as a repeat
        grab(s, st, ag);
        check(s == 0, "R7", "repeat slot", s, 0);
        check(ag == 1, "R7", "repeat kind", ag, 1);

        // R5: hold slot 1 offer while not accepted
        tick(3);
        check(tx_valid_o == 1, "R5", "held valid", int'(tx_valid_o), 1);
        check(tx_slot_o == 1, "R5", "held slot", int'(tx_slot_o), 1);
        grab(s, st, ag);
        check(s == 1 && ag == 1, "R7", "slot1 repeat", s, 1);
        grab(s, st, ag);
        check(s == 2 && ag == 1, "R7", "slot2 repeat", s, 2);

        // R3: fill up, head wraps with new generation
        for (int k = 3; k < N; k++) do_fill(k, 0, "R2");
        check(fill_ready_o == 0, "R3", "full", int'(fill_ready_o), 0);
        fill_req_i = 1; tick(1); fill_req_i = 0;
        check(fill_slot_o == 0, "R3", "slot unchanged", int'(fill_slot_o), 0);
        check(fill_set_o == 1, "R11", "set after wrap", int'(fill_set_o), 1);

        // R8 stale ack on slot 2, R10 slot 1 done behind open slot 0
        do_ack(2, 1);
        do_ack(1, 0);
        tick(3);
        check(fill_ready_o == 0, "R10", "blocked by tail", int'(fill_ready_o), 0);
        do_ack(0, 0);
        tick(3);
        do_fill(0, 1, "R10");
        do_fill(1, 1, "R10");
        check(fill_ready_o == 0, "R8", "stale ack freed nothing", int'(fill_ready_o), 0);

        // R8: ack of a never-sent slot is ignored
        do_ack(0, 1);
        // confirm slot 2 properly; it must drop out of the scan
        do_ack(2, 0);
        tick(2);
        check(fill_ready_o == 1, "R10", "slot2 retired", int'(fill_ready_o), 1);

        // R9: one pass covers every open slot except 2
        seen_mask = 0;
        for (int k = 0; k < N - 1; k++) begin
            grab(s, st, ag);
            check(s != 2, "R9", "done slot offered", s, -1);
            check(((seen_mask >> s) & 1) == 0, "R5", "slot once per pass", s, -1);
            seen_mask |= (1 << s);
            check(st == ((s < 2) ? 1 : 0), "R5", "offer set", st, (s < 2) ? 1 : 0);
            check(ag == 0, "R8", "unsent slot still first", ag, 0);
        end

        // R4: stop kills offer at once
        for (int i = 0; i < 4 * N && !tx_valid_o; i++) tick(1);
        stop_i = 1; #1;
        check(tx_valid_o == 0, "R4", "same-cycle stop", int'(tx_valid_o), 0);
        tick(1); stop_i = 0;
        tick(3);
        check(tx_valid_o == 0, "R4", "halted", int'(tx_valid_o), 0);
        pulse_cmd(1, 1);
        tick(2);
        check(tx_valid_o == 0, "R4", "stop beats start", int'(tx_valid_o), 0);
        pulse_cmd(1, 0);
        grab(s, st, ag);
        check(ag == 1, "R7", "resume repeat", ag, 1);

        // R11/R2 sweep from clean state across several wraps
        do_reset();
        pulse_cmd(1, 0);
        for (int k = 0; k < NSET * N + N; k++) begin
            for (int i = 0; i < 2 * N && !fill_ready_o; i++) tick(1);
            do_fill(k % N, (k / N) % NSET, "R11");
            grab(s, st, ag);
            check(s == k % N, "R11", "sweep slot", s, k % N);
            check(st == (k / N) % NSET, "R11", "sweep set", st, (k / N) % NSET);
            check(ag == 0, "R6", "sweep first", ag, 0);
            do_ack(s, st);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule